// File: doc/BRIEF.md
# Crosspoint Switch Control Store

This block holds the on/off state of every switch in a 12-row by 8-column analog crosspoint matrix. Each of the 96 switches has one storage cell; a 4-bit row address and a 3-bit column address pick one cell, and a single data bit decides whether that switch closes or opens. Any combination of switches may be closed at the same time, so one row can drive several columns and one column can gather several rows.

Writes are framed by a strobe and gated by a chip select, which lets several stores share one address and data bus. While the strobe stays high with the chip selected, the addressed cell follows the data bit. When the strobe falls, the cell keeps the last value it saw. A master clear input opens every switch at once, whether or not the chip is selected.

The model is fully synchronous. Every input is sampled on the system clock. Each cell is a flop, and a 96-bit enable vector stands in for the analog switches. Address and chip select are captured on the first clock at which the strobe is seen high, and they stay fixed for the rest of that strobe window.

Top module: `xpt_ctrl_store`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `sw_en` is 0 after that edge.
- R2: A clock edge at which `strobe` is low, with `master_clr` low, leaves `sw_en` unchanged.
- R3: At each clock edge within a strobe window whose captured chip select is 1, the addressed bit of `sw_en` takes the `data_in` level sampled at that edge. Data 1 closes the switch and data 0 opens it. A change on `data_in` inside the window therefore turns the switch on and off.
- R4: After `strobe` falls, the addressed bit keeps the `data_in` level sampled at the last clock edge where `strobe` was high.
- R5: A write changes only the bit at index row*8 + column of `sw_en`. All other bits keep their values, and at most one bit changes per clock.
- R6: `master_clr` high at a clock edge clears all 96 bits. It does this whether `chip_sel` is high or low, and it overrides a write at that edge.
- R7: A row address of 12 to 15 selects no cell, so a strobe window with such an address leaves `sw_en` unchanged.
- R8: Row, column and chip select are captured at the first edge where `strobe` is high. Later changes while `strobe` stays high do not move the write or cancel it.
- R9: Several bits in the same row or in the same column can be 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_addr | input | 4 | Row select, 0 to 11 valid |
| col_addr | input | 3 | Column select, 0 to 7 |
| data_in | input | 1 | Switch state to store: 1 closes, 0 opens |
| chip_sel | input | 1 | Active-high select, captured at strobe start |
| strobe | input | 1 | Active-high write window |
| master_clr | input | 1 | Active-high clear of all cells, ignores chip select |
| sw_en | output | 96 | Switch enables, bit index row*8 + column |

## Verification
The hardest case to reach from the ports is a long strobe window in which the data bit toggles while the address and chip select move under it. Only there can the bench show both things at once: the addressed cell tracks the data, and the latched address stays put. The directed window test holds the strobe high for several cycles, toggles the data and changes the address to a cell with a known value. At each step it checks both cells. It then drops the strobe in the same cycle that the data changes, to confirm which level is kept. Separate directed cases hold master clear against a selected write, and start a strobe with an out-of-range row.

// File: rtl/xpt_pkg.sv
// Package: default geometry of the crosspoint store and the cell index rule.
// Assumes: row-major layout, index = row * columns + column.
package xpt_pkg;
    localparam int XPT_ROWS = 12;
    localparam int XPT_COLS = 8;
    localparam int XPT_ROW_AW = 4;
    localparam int XPT_COL_AW = 3;
    localparam int XPT_CELLS = XPT_ROWS * XPT_COLS;

    // Flat cell index of a row/column pair.
    function automatic int cell_index(input int row, input int col, input int ncols);
        return row * ncols + col;
    endfunction
endpackage

// File: rtl/xpt_strobe_ctrl.sv
// Module: xpt_strobe_ctrl
// Watches the strobe and captures address and chip select on the first clock
// where the strobe is high. For the rest of the window it presents the captured
// values. Assumes strobe, chip_sel and addresses are synchronous to clk.
module xpt_strobe_ctrl #(
    parameter int ROW_AW = 4,
    parameter int COL_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              chip_sel,
    input  logic [ROW_AW-1:0] row_addr,
    input  logic [COL_AW-1:0] col_addr,
    output logic              wr_ok,
    output logic [ROW_AW-1:0] sel_row,
    output logic [COL_AW-1:0] sel_col
);
    logic              stb_q;
    logic              cs_q;
    logic [ROW_AW-1:0] row_q;
    logic [COL_AW-1:0] col_q;
    logic              first;

    // First clock of a strobe window.
    assign first = strobe && !stb_q;

    // Remember the strobe level and capture the request at window start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            cs_q  <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            stb_q <= strobe;
            if (first) begin
                cs_q  <= chip_sel;
                row_q <= row_addr;
                col_q <= col_addr;
            end
        end
    end

    // Choose the live request on the first clock and the captured one afterwards.
    always_comb begin
        if (first) begin
            sel_row = row_addr;
            sel_col = col_addr;
            wr_ok   = chip_sel;
        end else begin
            sel_row = row_q;
            sel_col = col_q;
            wr_ok   = strobe && cs_q;
        end
    end
endmodule

// File: rtl/xpt_addr_decode.sv
// Module: xpt_addr_decode
// Turns a row/column pair into a one-hot cell select, gated by a write enable.
// Row values at or above ROWS select nothing.
module xpt_addr_decode #(
    parameter int ROWS   = 12,
    parameter int COLS   = 8,
    parameter int ROW_AW = 4,
    parameter int COL_AW = 3,
    localparam int CELLS = ROWS * COLS
) (
    input  logic              wr_en,
    input  logic [ROW_AW-1:0] row,
    input  logic [COL_AW-1:0] col,
    output logic [CELLS-1:0]  hit
);
    // One comparator pair per cell.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign hit[xpt_pkg::cell_index(r, c, COLS)] =
                wr_en && (row == ROW_AW'(r)) && (col == COL_AW'(c));
        end
    end
endmodule

// File: rtl/xpt_cell_array.sv
// Module: xpt_cell_array
// One flop per switch. A selected cell loads the data bit, and clear empties
// every cell with priority over a load. Assumes hit is one-hot or zero.
module xpt_cell_array #(
    parameter int CELLS = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             data,
    input  logic [CELLS-1:0] hit,
    output logic [CELLS-1:0] cells
);
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        // Hold, load or clear one switch state.
        always_ff @(posedge clk) begin
            if (!rst_n)      cells[i] <= 1'b0;
            else if (clr)    cells[i] <= 1'b0;
            else if (hit[i]) cells[i] <= data;
        end
    end
endmodule

// File: rtl/xpt_ctrl_store.sv
// Module: xpt_ctrl_store (top)
// Control store for a ROWS x COLS crosspoint matrix. A write opens with the
// strobe, tracks data while the window lasts and keeps the last sampled level.
// Master clear empties the store regardless of chip select. All inputs are
// assumed synchronous to clk.
module xpt_ctrl_store #(
    parameter int ROWS   = xpt_pkg::XPT_ROWS,
    parameter int COLS   = xpt_pkg::XPT_COLS,
    parameter int ROW_AW = xpt_pkg::XPT_ROW_AW,
    parameter int COL_AW = xpt_pkg::XPT_COL_AW,
    localparam int CELLS = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] row_addr,
    input  logic [COL_AW-1:0] col_addr,
    input  logic              data_in,
    input  logic              chip_sel,
    input  logic              strobe,
    input  logic              master_clr,
    output logic [CELLS-1:0]  sw_en
);
    logic              wr_ok;
    logic [ROW_AW-1:0] sel_row;
    logic [COL_AW-1:0] sel_col;
    logic [CELLS-1:0]  hit;

    xpt_strobe_ctrl #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_stb (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .chip_sel(chip_sel),
        .row_addr(row_addr), .col_addr(col_addr),
        .wr_ok(wr_ok), .sel_row(sel_row), .sel_col(sel_col)
    );

    xpt_addr_decode #(.ROWS(ROWS), .COLS(COLS), .ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_dec (
        .wr_en(wr_ok), .row(sel_row), .col(sel_col), .hit(hit)
    );

    xpt_cell_array #(.CELLS(CELLS)) u_cells (
        .clk(clk), .rst_n(rst_n), .clr(master_clr), .data(data_in),
        .hit(hit), .cells(sw_en)
    );
endmodule

// File: rtl/xpt_ctrl_store_chk.sv
// Module: xpt_ctrl_store_chk
// Port-level assertions for xpt_ctrl_store, attached by bind. Holds its own
// one-cycle history of the inputs and outputs.
module xpt_ctrl_store_chk #(
    parameter int ROWS   = 12,
    parameter int COLS   = 8,
    parameter int ROW_AW = 4,
    localparam int CELLS = ROWS * COLS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROW_AW-1:0] row_addr,
    input logic              strobe,
    input logic              master_clr,
    input logic [CELLS-1:0]  sw_en
);
    logic [1:0]        seen = 2'd0;
    logic              rst_q, stb_q, stb_qq, clr_q;
    logic [ROW_AW-1:0] row_q;
    logic [CELLS-1:0]  en_q;

    // History of last-cycle values.
    always_ff @(posedge clk) begin
        if (seen != 2'd3) seen <= seen + 2'd1;
        rst_q  <= rst_n;
        stb_q  <= strobe;
        stb_qq <= stb_q;
        clr_q  <= master_clr;
        row_q  <= row_addr;
        en_q   <= sw_en;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        disable iff (seen < 2'd2) !rst_q |-> sw_en == '0);

    assert_clear_all_R6: assert property (@(posedge clk)
        disable iff (!rst_n || seen < 2'd2) (rst_q && clr_q) |-> sw_en == '0);

    assert_idle_stable_R2: assert property (@(posedge clk)
        disable iff (!rst_n || seen < 2'd2) (rst_q && !clr_q && !stb_q) |-> sw_en == en_q);

    assert_single_cell_R5: assert property (@(posedge clk)
        disable iff (!rst_n || seen < 2'd2) (rst_q && !clr_q) |-> $countones(sw_en ^ en_q) <= 1);

    assert_bad_row_R7: assert property (@(posedge clk)
        disable iff (!rst_n || seen < 2'd3)
        (rst_q && !clr_q && stb_q && !stb_qq && (row_q >= ROW_AW'(ROWS))) |-> sw_en == en_q);
endmodule

bind xpt_ctrl_store xpt_ctrl_store_chk #(.ROWS(ROWS), .COLS(COLS), .ROW_AW(ROW_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .strobe(strobe),
    .master_clr(master_clr), .sw_en(sw_en)
);

// File: tb/xpt_ctrl_store_tb_top.sv
// Bench for xpt_ctrl_store: a vector table of single writes, then directed
// tests for reset, master clear, strobe windows and bad rows.
module xpt_ctrl_store_tb_top;
    localparam int ROWS = 12;
    localparam int COLS = 8;
    localparam int CELLS = ROWS * COLS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       row_addr = '0;
    logic [2:0]       col_addr = '0;
    logic             data_in = 1'b0;
    logic             chip_sel = 1'b0;
    logic             strobe = 1'b0;
    logic             master_clr = 1'b0;
    logic [CELLS-1:0] sw_en;
    logic [CELLS-1:0] model;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xpt_ctrl_store dut_i (
        .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .col_addr(col_addr),
        .data_in(data_in), .chip_sel(chip_sel), .strobe(strobe),
        .master_clr(master_clr), .sw_en(sw_en)
    );

    // Vector: {row[3:0], col[2:0], data, cs}
    localparam int NV = 12;
    localparam logic [8:0] VEC [NV] = '{
        {4'd0,  3'd0, 1'b1, 1'b1}, {4'd11, 3'd7, 1'b1, 1'b1},
        {4'd5,  3'd3, 1'b1, 1'b1}, {4'd5,  3'd6, 1'b1, 1'b1},
        {4'd2,  3'd3, 1'b1, 1'b1}, {4'd5,  3'd3, 1'b0, 1'b1},
        {4'd7,  3'd1, 1'b1, 1'b0}, {4'd11, 3'd7, 1'b0, 1'b0},
        {4'd13, 3'd2, 1'b1, 1'b1}, {4'd15, 3'd7, 1'b1, 1'b1},
        {4'd0,  3'd0, 1'b1, 1'b1}, {4'd9,  3'd4, 1'b1, 1'b1}
    };

    task automatic check_vec(input string tag, input logic [CELLS-1:0] exp);
        checks++;
        if (sw_en !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, sw_en, exp);
        end
    endtask

    task automatic check_bit(input string tag, input int idx, input logic exp);
        checks++;
        if (sw_en[idx] !== exp) begin
            errors++;
            $display("FAIL %s: bit %0d got %b expected %b", tag, idx, sw_en[idx], exp);
        end
    endtask

    // One-clock strobe pulse; inputs change on the falling edge.
    task automatic pulse_write(input logic [3:0] r, input logic [2:0] c,
                               input logic d, input logic cs);
        row_addr = r; col_addr = c; data_in = d; chip_sel = cs; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        if (cs && r < 4'(ROWS)) model[int'(r) * COLS + int'(c)] = d;
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        model = '0;
        repeat (3) @(negedge clk);
        check_vec("R1 reset state", '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 single writes, R5 isolation, R7 bad rows, R9 shared row/column.
        for (int i = 0; i < NV; i++) begin
            pulse_write(VEC[i][8:5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
            check_vec($sformatf("R3/R5/R7/R9 vector %0d", i), model);
        end
        checks++;
        if (!(sw_en[5*COLS+6] && sw_en[2*COLS+3] && sw_en[9*COLS+4])) begin
            errors++;
            $display("FAIL R9: got %h expected shared row/column bits set", sw_en);
        end

        // R2: idle clocks with bus activity but no strobe.
        chip_sel = 1'b1; data_in = 1'b1; row_addr = 4'd3; col_addr = 3'd3;
        repeat (3) @(negedge clk);
        chip_sel = 1'b0;
        check_vec("R2 no strobe", model);

        // R3/R4/R8: long window, data toggles, address moves under it.
        row_addr = 4'd1; col_addr = 3'd2; data_in = 1'b1; chip_sel = 1'b1; strobe = 1'b1;
        @(negedge clk);
        check_bit("R3 track high", 1*COLS+2, 1'b1);
        data_in = 1'b0; row_addr = 4'd0; col_addr = 3'd0; chip_sel = 1'b0;
        @(negedge clk);
        check_bit("R3 track low", 1*COLS+2, 1'b0);
        check_bit("R8 moved address ignored", 0, 1'b1);
        data_in = 1'b1;
        @(negedge clk);
        check_bit("R8 chip select drop ignored", 1*COLS+2, 1'b1);
        strobe = 1'b0; data_in = 1'b0;
        @(negedge clk);
        model[1*COLS+2] = 1'b1;
        check_vec("R4 hold last level", model);

        // R7: window with a bad row held for several clocks.
        row_addr = 4'd12; col_addr = 3'd0; data_in = 1'b1; chip_sel = 1'b1; strobe = 1'b1;
        repeat (2) @(negedge clk);
        row_addr = 4'd4;
        @(negedge clk);
        strobe = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        check_vec("R7 bad row window", model);

        // R6: clear with chip select low, and clear overriding a write.
        master_clr = 1'b1;
        @(negedge clk);
        master_clr = 1'b0;
        model = '0;
        check_vec("R6 clear with cs low", model);
        pulse_write(4'd6, 3'd1, 1'b1, 1'b1);
        row_addr = 4'd8; col_addr = 3'd5; data_in = 1'b1; chip_sel = 1'b1; strobe = 1'b1;
        master_clr = 1'b1;
        @(negedge clk);
        master_clr = 1'b0; strobe = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        check_vec("R6 clear overrides write", '0);

        // R1: reset after content exists.
        pulse_write(4'd10, 3'd6, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R1 reset clears content", '0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule